// File: doc/BRIEF.md
# Masked calendar alarm comparator

This block watches a packed calendar time word and raises an alarm when it equals a programmed alarm word. A 3-bit selector sets how many fields take part in the comparison. The fields always start at seconds and extend upward, so each selector step adds the next larger field.

The comparison runs only in a cycle where the tick strobe marks a new time value. A hit sets a sticky alarm flag. Software clears the flag by writing 1 to bit 8 of the flag write port. On a hit the block can also:

- drive an interrupt, gated by an enable that has separate set and clear strobes;
- emit a one-cycle event pulse, gated by its own enable;
- ask the external time counter to clear itself.

The flag is held by a two-state machine:

- `ALM_IDLE` means no alarm is pending.
- `ALM_LATCHED` means an alarm is pending.

It moves between them on two transitions:

- **IDLE→LATCHED** is taken on a qualifying tick that hits.
- **LATCHED→IDLE** is taken on a flag write with bit 8 set, when no hit arrives in the same cycle.

Every other case holds the current state.

Top module: `calendar_alarm_match`

## Requirements
- R1: The time word and the alarm word share one layout: seconds in bits 5:0, minutes in 11:6, hours in 16:12, day in 21:17, month in 25:22 and year in 31:26. The selector values 1 to 6 compare 1 to 6 fields, counting from seconds upward. A difference in any bit outside the selected fields does not prevent a hit.
- R2: Selector values 0 and 7 never produce a hit.
- R3: A hit is recognised only in a cycle where `tick` is high. A time that matches while `tick` is low sets nothing.
- R4: The alarm flag rises on the clock edge after a hit and stays set. It is cleared only by a cycle with `flag_wr` high and `flag_wdata[8]` high. A flag write with bit 8 low has no effect.
- R5: When a hit and a clearing flag write arrive in the same cycle, the flag is set after that edge.
- R6: The interrupt enable is 0 after reset. A pulse on `ien_set` sets it and a pulse on `ien_clr` clears it; when both pulse together, the clear wins. `irq` is high exactly when both the flag and the enable are set.
- R7: `evt_pulse` is high for exactly one cycle after each hit for which `evt_en` was high. Otherwise it stays low.
- R8: `cnt_clr_req` is high for exactly one cycle after each hit for which `clr_on_match` was high.
- R9: After reset, the flag, `irq`, `evt_pulse` and `cnt_clr_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Marks a cycle that carries a new time value |
| time_word | input | 32 | Current packed calendar time |
| alarm_word | input | 32 | Programmed alarm time, same layout |
| sel | input | 3 | Number of fields compared, from seconds upward |
| clr_on_match | input | 1 | Request a time-counter clear on each hit |
| evt_en | input | 1 | Enable for the event pulse |
| ien_set | input | 1 | Strobe that sets the interrupt enable |
| ien_clr | input | 1 | Strobe that clears the interrupt enable |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 16 | Flag write data; a 1 in bit 8 clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq | output | 1 | Interrupt line |
| evt_pulse | output | 1 | One-cycle event on a hit |
| cnt_clr_req | output | 1 | One-cycle request to clear the time counter |

## Verification
The bench sweeps every selector value against time words that differ from the alarm in exactly one field, and against time words that are identical to it.

- A mask that is one field too narrow or too wide shows up as a hit on the wrong side of the selector boundary.
- A design that treats selector 7 as "compare all" fires where no hit is expected.

Directed cases cover the pipeline timing and the priority rules:

- A matching time held with no tick must leave the flag clear; a design that compares on every clock would set it.
- A hit coinciding with a clear must leave the flag set; the wrong priority would drop the alarm.
- A write with bit 8 low must leave the flag set; a design that decodes the wrong bit would clear it.
- Simultaneous enable set and clear must leave the interrupt low; reversed priority would raise `irq`.

// File: rtl/calarm_pkg.sv
package calarm_pkg;
    localparam int TIME_W    = 32;
    localparam int NFIELD    = 6;
    localparam int SEL_W     = 3;
    localparam int FLAG_W    = 16;
    localparam int ALARM_BIT = 8;

    // Lowest bit of calendar field i (seconds = 0 ... year = 5)
    function automatic int field_lo(input int i);
        case (i)
            0: return 0;
            1: return 6;
            2: return 12;
            3: return 17;
            4: return 22;
            default: return 26;
        endcase
    endfunction

    // Highest bit of calendar field i
    function automatic int field_hi(input int i);
        case (i)
            0: return 5;
            1: return 11;
            2: return 16;
            3: return 21;
            4: return 25;
            default: return 31;
        endcase
    endfunction

    typedef enum logic {
        ALM_IDLE    = 1'b0,
        ALM_LATCHED = 1'b1
    } alm_state_t;
endpackage

// File: rtl/calarm_field_cmp.sv
module calarm_field_cmp
    import calarm_pkg::*;
#(
    parameter int TW = TIME_W,
    parameter int NF = NFIELD,
    parameter int SW = SEL_W
) (
    input  logic [TW-1:0] time_word,
    input  logic [TW-1:0] alarm_word,
    input  logic [SW-1:0] sel,
    output logic          hit_raw
);
    logic [NF-1:0] fld_eq;
    logic [NF-1:0] fld_used;
    logic          sel_ok;

    generate
        for (genvar i = 0; i < NF; i++) begin : g_fld
            localparam int LO = field_lo(i);
            localparam int HI = field_hi(i);
            assign fld_eq[i]   = (time_word[HI:LO] == alarm_word[HI:LO]);
            assign fld_used[i] = (32'(sel) > i);
        end
    endgenerate

    assign sel_ok  = (sel != '0) && (32'(sel) <= NF);
    assign hit_raw = sel_ok && (&(fld_eq | ~fld_used));
endmodule

// File: rtl/calarm_flag_fsm.sv
module calarm_flag_fsm
    import calarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_wr,
    input  logic evt_en,
    input  logic clr_on_match,
    output logic flag,
    output logic evt_pulse,
    output logic cnt_clr_req
);
    alm_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE:    if (hit)            state_d = ALM_LATCHED;
            ALM_LATCHED: if (clr_wr && !hit) state_d = ALM_IDLE;
            default:                         state_d = ALM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ALM_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse   <= 1'b0;
            cnt_clr_req <= 1'b0;
        end else begin
            evt_pulse   <= hit && evt_en;
            cnt_clr_req <= hit && clr_on_match;
        end
    end

    assign flag = (state_q == ALM_LATCHED);
endmodule

// File: rtl/calarm_ien_reg.sv
module calarm_ien_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_strb,
    input  logic clr_strb,
    output logic en
);
    always_ff @(posedge clk) begin
        if (!rst_n)        en <= 1'b0;
        else if (clr_strb) en <= 1'b0;
        else if (set_strb) en <= 1'b1;
    end
endmodule

// File: rtl/calendar_alarm_match.sv
module calendar_alarm_match
    import calarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [TIME_W-1:0] time_word,
    input  logic [TIME_W-1:0] alarm_word,
    input  logic [SEL_W-1:0]  sel,
    input  logic              clr_on_match,
    input  logic              evt_en,
    input  logic              ien_set,
    input  logic              ien_clr,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic              alarm_flag,
    output logic              irq,
    output logic              evt_pulse,
    output logic              cnt_clr_req
);
    logic hit_raw;
    logic hit;
    logic ien;
    logic clr_wr;

    calarm_field_cmp #(.TW(TIME_W), .NF(NFIELD), .SW(SEL_W)) u_cmp (
        .time_word (time_word),
        .alarm_word(alarm_word),
        .sel       (sel),
        .hit_raw   (hit_raw)
    );

    assign hit    = hit_raw && tick;
    assign clr_wr = flag_wr && flag_wdata[ALARM_BIT];

    calarm_flag_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .clr_wr      (clr_wr),
        .evt_en      (evt_en),
        .clr_on_match(clr_on_match),
        .flag        (alarm_flag),
        .evt_pulse   (evt_pulse),
        .cnt_clr_req (cnt_clr_req)
    );

    calarm_ien_reg u_ien (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_strb(ien_set),
        .clr_strb(ien_clr),
        .en      (ien)
    );

    assign irq = alarm_flag && ien;
endmodule

// File: rtl/calarm_checker.sv
module calarm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic [2:0]  sel,
    input logic        clr_on_match,
    input logic        evt_en,
    input logic        ien_clr,
    input logic        flag_wr,
    input logic [15:0] flag_wdata,
    input logic        alarm_flag,
    input logic        irq,
    input logic        evt_pulse,
    input logic        cnt_clr_req
);
    // R3
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(tick));

    // R2
    disabled_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> ($past(sel) != 3'd0 && $past(sel) != 3'd7));

    // R4
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> ($past(flag_wr) && $past(flag_wdata[8])));

    // R4
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_wr) && $past(flag_wdata[8]) && !$past(tick)) |-> !alarm_flag);

    // R6
    ien_clr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ien_clr) |-> !irq);

    // R7
    evt_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> ($past(evt_en) && $past(tick)));

    // R8
    clr_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_req |-> ($past(clr_on_match) && $past(tick)));

    // R8
    clr_req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_req |-> alarm_flag);
endmodule

bind calendar_alarm_match calarm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sel         (sel),
    .clr_on_match(clr_on_match),
    .evt_en      (evt_en),
    .ien_clr     (ien_clr),
    .flag_wr     (flag_wr),
    .flag_wdata  (flag_wdata),
    .alarm_flag  (alarm_flag),
    .irq         (irq),
    .evt_pulse   (evt_pulse),
    .cnt_clr_req (cnt_clr_req)
);

// File: tb/calendar_alarm_match_test.sv
module calendar_alarm_match_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [31:0] time_word = '0;
    logic [31:0] alarm_word = '0;
    logic [2:0]  sel = '0;
    logic        clr_on_match = 1'b0;
    logic        evt_en = 1'b0;
    logic        ien_set = 1'b0;
    logic        ien_clr = 1'b0;
    logic        flag_wr = 1'b0;
    logic [15:0] flag_wdata = '0;
    logic        alarm_flag, irq, evt_pulse, cnt_clr_req;

    int n_vec = 0;
    int n_bad = 0;
    bit ien_model = 1'b0;

    always #5 clk = ~clk;

    calendar_alarm_match uut (.*);

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lo_of(input int i);
        int t[6] = '{0, 6, 12, 17, 22, 26};
        return t[i];
    endfunction

    // Clear flag via bit 8 and confirm
    task automatic clear_flag();
        flag_wr = 1'b1; flag_wdata = 16'h0100;
        @(negedge clk);
        flag_wr = 1'b0; flag_wdata = '0;
        check("R4 clear", alarm_flag, 1'b0);
    endtask

    // One tick with given words; check registered outputs one cycle later
    task automatic run_vec(input logic [31:0] a, input logic [31:0] t, input logic [2:0] s, input bit exp);
        alarm_word = a; time_word = t; sel = s; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check((s == 0 || s == 7) ? "R2 sel" : "R1 mask", alarm_flag, exp);
        check("R7 evt", evt_pulse, exp & evt_en);
        check("R8 clrreq", cnt_clr_req, exp & clr_on_match);
        check("R6 irq", irq, exp & ien_model);
        @(negedge clk);
        check("R7 one-cycle", evt_pulse, 1'b0);
        check("R8 one-cycle", cnt_clr_req, 1'b0);
        clear_flag();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 flag", alarm_flag, 1'b0);
        check("R9 irq", irq, 1'b0);
        check("R9 evt", evt_pulse, 1'b0);
        check("R9 clrreq", cnt_clr_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2 sweep: every selector vs single-field mismatches and exact match
        for (int pass = 0; pass < 3; pass++) begin
            logic [31:0] a;
            a = 32'h9E37_79B9 * (pass + 1);
            evt_en = pass[0];
            clr_on_match = pass[1];
            if (pass == 2) begin
                ien_set = 1'b1; @(negedge clk); ien_set = 1'b0; ien_model = 1'b1;
            end
            for (int s = 0; s < 8; s++) begin
                bit en;
                en = (s >= 1 && s <= 6);
                run_vec(a, a, 3'(s), en);
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] t;
                    t = a ^ (32'd1 << lo_of(k));
                    run_vec(a, t, 3'(s), en && (k >= s));
                end
            end
        end

        // R3: matching time with no tick
        alarm_word = 32'h1234_5678; time_word = 32'h1234_5678; sel = 3'd6;
        repeat (3) @(negedge clk);
        check("R3 no tick", alarm_flag, 1'b0);

        // R4: write with bit 8 low leaves flag set
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        check("R4 set", alarm_flag, 1'b1);
        flag_wr = 1'b1; flag_wdata = 16'hFEFF; @(negedge clk); flag_wr = 1'b0;
        check("R4 ignored write", alarm_flag, 1'b1);
        repeat (2) @(negedge clk);
        check("R4 sticky", alarm_flag, 1'b1);

        // R5: hit and clear in the same cycle, flag already set
        tick = 1'b1; flag_wr = 1'b1; flag_wdata = 16'h0100;
        @(negedge clk);
        tick = 1'b0; flag_wr = 1'b0;
        check("R5 set+clear", alarm_flag, 1'b1);
        clear_flag();
        // R5: same, starting from clear flag
        tick = 1'b1; flag_wr = 1'b1; flag_wdata = 16'h0100;
        @(negedge clk);
        tick = 1'b0; flag_wr = 1'b0;
        check("R5 idle set+clear", alarm_flag, 1'b1);

        // R6: enable set/clear priority
        check("R6 irq enabled", irq, 1'b1);
        ien_clr = 1'b1; @(negedge clk); ien_clr = 1'b0;
        check("R6 clr", irq, 1'b0);
        ien_set = 1'b1; @(negedge clk); ien_set = 1'b0;
        check("R6 set", irq, 1'b1);
        ien_set = 1'b1; ien_clr = 1'b1; @(negedge clk); ien_set = 1'b0; ien_clr = 1'b0;
        check("R6 clear wins", irq, 1'b0);
        check("R6 flag kept", alarm_flag, 1'b1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule